// File: doc/BRIEF.md
# Configurable-Pipeline Signed Multiplier

This block multiplies two 18-bit two's-complement operands and delivers the full 36-bit signed product. Four register stages sit along the path, and a parameter switches each one on or off: a register on operand A, a register on operand B, a register directly after the multiplier, and a register on the product output. The two operand registers together form one stage. The other two are one stage each, so the latency runs from zero to three cycles.

A bypass parameter overrides every stage enable and leaves a purely combinational multiplier. The block reports its latency on a constant output, so that logic around it can line up its own delay chains. A clock enable freezes every register that is present. A synchronous reset clears them. Unsigned 16-bit quantities are multiplied by zero-extending them to 18 bits, so the sign bit is 0.

Top module: `smul_pipe`

## Requirements
- R1: Operands are 18-bit two's complement with the sign in bit 17. The product is the exact 36-bit two's-complement result of the multiplication.
- R2: The extreme operands give exact results. -131072 × -131072 = 17179869184 (2^34). -131072 × 131071 = -17179738112. 131071 × 131071 = 17179607041.
- R3: The latency in clock cycles equals the number of enabled stages. The two operand registers count as one stage when either or both are enabled. The post-multiply register and the output register count as one stage each. With all four enabled, the latency is 3 cycles.
- R4: When `rst` is high at a rising clock edge, every enabled register is cleared to zero at that edge, whatever the level of `ce`. Every registered configuration then outputs a product of 0.
- R5: When `ce` is low and `rst` is low at a rising edge, every enabled register keeps its value. The output of a registered configuration does not change when the operands change.
- R6: With bypass selected, `product` follows the present operands combinationally. This holds regardless of the stage enables, `rst` and `ce`.
- R7: `latency` carries the stage count of R3 as an unsigned 2-bit number. In bypass it reads 0.
- R8: Two unsigned 16-bit values that are zero-extended to 18 bits give their unsigned product. For example, 65535 × 65535 = 4294836225.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable for all enabled registers |
| op_a | input | 18 | Operand A, two's complement |
| op_b | input | 18 | Operand B, two's complement |
| product | output | 36 | Signed product |
| latency | output | 2 | Number of enabled stages, constant |

## Verification
Five copies of the block run side by side, each in a different configuration: all stages enabled, bypass, three stages, one stage, and none. They all receive the same operand streams.

A new operand pair applied every cycle separates the configurations by the cycle in which each new product appears. Mixed-sign pairs and zero operands expose errors in sign handling. The extreme pairs and the zero-extended 16-bit pair expose truncation or wrong sign extension in the upper product bits.

Changing the operands while `ce` is low, and raising `rst` while `ce` is low, separates holding from clearing. A bypass check taken before any clock edge shows that no register was left in the path.

// File: rtl/smul_pkg.sv
package smul_pkg;

    // Stage count of a configuration: both operand registers form one stage.
    function automatic int unsigned stage_count(
        input bit en_a,
        input bit en_b,
        input bit en_mid,
        input bit en_out,
        input bit bypass
    );
        int unsigned n;
        n = 0;
        if (!bypass) begin
            if (en_a || en_b) n = n + 1;
            if (en_mid)       n = n + 1;
            if (en_out)       n = n + 1;
        end
        return n;
    endfunction

endpackage

// File: rtl/smul_stage.sv
module smul_stage #(
    parameter int unsigned W  = 18,
    parameter bit          EN = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ce,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    typedef struct packed {
        logic [W-1:0] val;
    } stage_t;

    generate
        if (EN) begin : g_reg
            stage_t st_d;
            stage_t st_q;

            always_comb begin
                st_d = st_q;
                if (rst) begin
                    st_d.val = '0;
                end else if (ce) begin
                    st_d.val = d_i;
                end
            end

            always_ff @(posedge clk) begin
                st_q <= st_d;
            end

            assign q_o = st_q.val;

            // R5: a stage with clock enable low keeps its contents
            p_hold_r5: assert property (@(posedge clk) disable iff (rst)
                !ce |=> $stable(q_o));

            // R4: reset clears the stage at the edge, clock enable or not
            p_clear_r4: assert property (@(posedge clk)
                rst |=> (q_o == '0));
        end else begin : g_wire
            assign q_o = d_i;
        end
    endgenerate

endmodule

// File: rtl/smul_core.sv
module smul_core #(
    parameter int unsigned A_W = 18,
    parameter int unsigned B_W = 18
) (
    input  logic [A_W-1:0]     a_i,
    input  logic [B_W-1:0]     b_i,
    output logic [A_W+B_W-1:0] p_o
);

    localparam int unsigned P_W   = A_W + B_W;
    localparam longint      P_MAX = longint'(1) << (A_W + B_W - 2);

    logic signed [P_W-1:0] ax_d;
    logic signed [P_W-1:0] bx_d;

    always_comb begin
        ax_d = P_W'($signed(a_i));
        bx_d = P_W'($signed(b_i));
        p_o  = ax_d * bx_d;
    end

    always_comb begin
        if (!$isunknown({a_i, b_i})) begin
            // R1: sign of a nonzero product is the xor of operand signs
            if (a_i != '0 && b_i != '0) begin
                p_sign_r1: assert (p_o[P_W-1] == (a_i[A_W-1] ^ b_i[B_W-1]));
            end
            // R2: magnitude never exceeds the square of the most negative operand
            p_range_r2: assert (longint'($signed(p_o)) <= P_MAX &&
                                longint'($signed(p_o)) >= -P_MAX);
        end
    end

endmodule

// File: rtl/smul_pipe.sv
module smul_pipe
    import smul_pkg::*;
#(
    parameter int unsigned A_W    = 18,
    parameter int unsigned B_W    = 18,
    parameter bit          EN_A   = 1'b1,
    parameter bit          EN_B   = 1'b1,
    parameter bit          EN_MID = 1'b1,
    parameter bit          EN_OUT = 1'b1,
    parameter bit          BYPASS = 1'b0,
    localparam int unsigned P_W   = A_W + B_W,
    localparam int unsigned LAT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ce,
    input  logic [A_W-1:0]   op_a,
    input  logic [B_W-1:0]   op_b,
    output logic [P_W-1:0]   product,
    output logic [LAT_W-1:0] latency
);

    localparam bit USE_A   = EN_A   && !BYPASS;
    localparam bit USE_B   = EN_B   && !BYPASS;
    localparam bit USE_MID = EN_MID && !BYPASS;
    localparam bit USE_OUT = EN_OUT && !BYPASS;
    localparam int unsigned LAT = stage_count(EN_A, EN_B, EN_MID, EN_OUT, BYPASS);

    logic [A_W-1:0] a_q;
    logic [B_W-1:0] b_q;
    logic [P_W-1:0] raw_p;
    logic [P_W-1:0] mid_q;

    assign latency = LAT_W'(LAT);

    smul_stage #(.W(A_W), .EN(USE_A)) u_reg_a (
        .clk(clk), .rst(rst), .ce(ce), .d_i(op_a), .q_o(a_q)
    );

    smul_stage #(.W(B_W), .EN(USE_B)) u_reg_b (
        .clk(clk), .rst(rst), .ce(ce), .d_i(op_b), .q_o(b_q)
    );

    smul_core #(.A_W(A_W), .B_W(B_W)) u_core (
        .a_i(a_q), .b_i(b_q), .p_o(raw_p)
    );

    smul_stage #(.W(P_W), .EN(USE_MID)) u_reg_mid (
        .clk(clk), .rst(rst), .ce(ce), .d_i(raw_p), .q_o(mid_q)
    );

    smul_stage #(.W(P_W), .EN(USE_OUT)) u_reg_out (
        .clk(clk), .rst(rst), .ce(ce), .d_i(mid_q), .q_o(product)
    );

    generate
        if (BYPASS) begin : g_byp_chk
            // R6: in bypass the port product always matches the present operands
            p_bypass_comb_r6: assert property (@(posedge clk)
                product == P_W'(P_W'($signed(op_a)) * P_W'($signed(op_b))));
        end
    endgenerate

endmodule

// File: tb/test_smul_pipe.sv
module test_smul_pipe;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ce  = 1'b0;
    logic signed [17:0] a_s = '0;
    logic signed [17:0] b_s = '0;

    logic [35:0] p_full, p_byp, p_mid, p_pip, p_raw;
    logic [1:0]  l_full, l_byp, l_mid, l_pip, l_raw;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    longint mdl [1:3] = '{default: 0};

    always #5 clk = ~clk;

    smul_pipe i_smul_pipe (
        .clk(clk), .rst(rst), .ce(ce), .op_a(a_s), .op_b(b_s),
        .product(p_full), .latency(l_full)
    );
    smul_pipe #(.BYPASS(1'b1)) i_smul_pipe_byp (
        .clk(clk), .rst(rst), .ce(ce), .op_a(a_s), .op_b(b_s),
        .product(p_byp), .latency(l_byp)
    );
    smul_pipe #(.EN_MID(1'b0)) i_smul_pipe_mid (
        .clk(clk), .rst(rst), .ce(ce), .op_a(a_s), .op_b(b_s),
        .product(p_mid), .latency(l_mid)
    );
    smul_pipe #(.EN_A(1'b0), .EN_B(1'b0), .EN_OUT(1'b0)) i_smul_pipe_pip (
        .clk(clk), .rst(rst), .ce(ce), .op_a(a_s), .op_b(b_s),
        .product(p_pip), .latency(l_pip)
    );
    smul_pipe #(.EN_A(1'b0), .EN_B(1'b0), .EN_MID(1'b0), .EN_OUT(1'b0)) i_smul_pipe_raw (
        .clk(clk), .rst(rst), .ce(ce), .op_a(a_s), .op_b(b_s),
        .product(p_raw), .latency(l_raw)
    );

    function automatic longint cur_prod();
        return longint'(a_s) * longint'(b_s);
    endfunction

    function automatic longint sx(input logic [35:0] v);
        return longint'($signed(v));
    endfunction

    function automatic longint expect_for(input int lat);
        if (lat == 0) return cur_prod();
        return mdl[lat];
    endfunction

    task automatic chk(input string tag, input string who, input longint got, input longint exp);
        nchk++;
        if (got != exp) begin
            nerr++;
            $display("FAIL %s [%s] actual=%0d expected=%0d", tag, who, got, exp);
        end
    endtask

    // One rising edge; the model is updated from R3/R4/R5, then sample at the falling edge.
    task automatic tick();
        longint p0;
        p0 = cur_prod();
        @(posedge clk);
        if (rst) begin
            mdl[1] = 0; mdl[2] = 0; mdl[3] = 0;
        end else if (ce) begin
            mdl[3] = mdl[2]; mdl[2] = mdl[1]; mdl[1] = p0;
        end
        @(negedge clk);
    endtask

    task automatic check_all(input string tag);
        chk(tag, "full", sx(p_full), expect_for(3));
        chk(tag, "bypass", sx(p_byp), expect_for(0));
        chk(tag, "mid-off", sx(p_mid), expect_for(2));
        chk(tag, "pipe-only", sx(p_pip), expect_for(1));
        chk(tag, "no-regs", sx(p_raw), expect_for(0));
    endtask

    task automatic drive(input longint a, input longint b);
        a_s = 18'(a);
        b_s = 18'(b);
    endtask

    task automatic t_reset();
        rst = 1'b1; ce = 1'b1;
        drive(1234, -77);
        tick(); tick();
        check_all("R4 reset clears registers");
        rst = 1'b0;
        tick(); tick(); tick();
        check_all("R4 load after reset");
        rst = 1'b1; ce = 1'b0;
        tick();
        check_all("R4 reset wins over ce low");
        chk("R4 reset wins over ce low", "full literal", sx(p_full), 0);
        rst = 1'b0; ce = 1'b1;
    endtask

    task automatic t_latency();
        drive(0, 0);
        tick(); tick(); tick();
        drive(3, 5);     tick(); check_all("R3 latency step 1");
        drive(-7, 11);   tick(); check_all("R3 latency step 2");
        drive(100, -100); tick(); check_all("R3 latency step 3");
        drive(0, 9);     tick(); check_all("R3 latency step 4");
        drive(1, 1);     tick(); check_all("R3 latency step 5");
        tick(); check_all("R3 latency drain");
        chk("R7 latency port", "full", l_full, 3);
        chk("R7 latency port", "bypass", l_byp, 0);
        chk("R7 latency port", "mid-off", l_mid, 2);
        chk("R7 latency port", "pipe-only", l_pip, 1);
        chk("R7 latency port", "no-regs", l_raw, 0);
    endtask

    task automatic t_signs();
        drive(25, 40);      tick(); check_all("R1 pos x pos");
        drive(25, -40);     tick(); check_all("R1 pos x neg");
        drive(-25, 40);     tick(); check_all("R1 neg x pos");
        drive(-25, -40);    tick(); check_all("R1 neg x neg");
        drive(-1, -1);      tick(); check_all("R1 minus one squared");
        drive(0, -99999);   tick(); check_all("R1 zero operand");
        drive(-1, 131071);  tick(); check_all("R1 minus one times max");
        tick(); tick(); tick(); check_all("R1 drain");
    endtask

    task automatic t_corner();
        drive(-131072, -131072); tick(); tick(); tick();
        check_all("R2 min x min");
        chk("R2 min x min", "full literal", sx(p_full), 64'sd17179869184);
        drive(-131072, 131071); tick(); tick(); tick();
        check_all("R2 min x max");
        chk("R2 min x max", "full literal", sx(p_full), -64'sd17179738112);
        drive(131071, 131071); tick(); tick(); tick();
        check_all("R2 max x max");
        chk("R2 max x max", "full literal", sx(p_full), 64'sd17179607041);
    endtask

    task automatic t_unsigned();
        a_s = {2'b00, 16'hFFFF};
        b_s = {2'b00, 16'hFFFF};
        tick(); tick(); tick();
        check_all("R8 zero-extended operands");
        chk("R8 zero-extended operands", "full literal", sx(p_full), 64'sd4294836225);
    endtask

    task automatic t_hold();
        drive(321, -654); tick(); tick(); tick();
        check_all("R5 before hold");
        ce = 1'b0;
        drive(-5000, 77); tick();
        check_all("R5 hold cycle 1");
        chk("R5 hold cycle 1", "full literal", sx(p_full), -64'sd209934);
        drive(9, 9); tick();
        check_all("R5 hold cycle 2");
        chk("R5 hold cycle 2", "full literal", sx(p_full), -64'sd209934);
        ce = 1'b1;
        tick(); tick(); tick();
        check_all("R5 resume after hold");
    endtask

    task automatic t_bypass();
        rst = 1'b1; ce = 1'b0;
        drive(-1111, 2222);
        #1;
        chk("R6 bypass before any edge", "bypass", sx(p_byp), -64'sd2468642);
        drive(131071, -131072);
        #1;
        chk("R6 bypass follows new operands", "bypass", sx(p_byp), cur_prod());
        tick();
        check_all("R6 bypass during reset");
        rst = 1'b0; ce = 1'b1;
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_latency();
        t_signs();
        t_corner();
        t_unsigned();
        t_hold();
        t_bypass();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

endmodule